// File: doc/BRIEF.md
# Two-Wire Register Slave with Separate Acknowledge Output

This block is a two-wire serial slave that gives a host controller write and read access to a byte-wide register file. The host drives a serial clock and a serial data line. A high-to-low data edge while the clock is high opens a transfer, and a low-to-high data edge while the clock is high closes it. The slave never drives the data line. Its acknowledge and its read data leave on a dedicated output pin, and read data appear there inverted.

A write transfer carries three kinds of byte, in this order:
- the write device byte;
- a register pointer byte;
- any number of data bytes.

The pointer steps by one after every data byte. A read first sets the pointer with a write transfer. After a stop and a fresh start, the host sends the read device byte and then clocks bytes out from the pointer, one after another. Every byte takes nine clocks: eight data bits MSB first, then one acknowledge slot. Both inputs are asynchronous to the system clock and pass through synchronizers. Each bus edge therefore reaches the register state three system clocks after it happens on the pins.

The register file itself sits outside this block. The block presents a pointer address, a single-cycle write strobe with write data, and a combinational read-data input.

Top module: `twr_slave`

## Requirements
- R1: While reset is held and right after it, ack_o is 0, reg_we_o is 0 and reg_addr_o is 0.
- R2: The slave raises ack_o in the acknowledge slot of the device byte only when that byte equals the write code {DEV_ADDR,0} (24h by default) or the read code {DEV_ADDR,1} (25h by default). Any other device byte gets no acknowledge, and no register is written until the next start.
- R3: In a write transfer, the byte after the device byte loads the pointer. Each following byte, taken MSB first, is written to the pointer with a reg_we_o pulse one system clock long. The pointer then increases by one, and a transfer may hold any number of data bytes.
- R4: In a write transfer, ack_o rises after the falling clock that ends bit 8 of the pointer or data byte. It stays high through the acknowledge slot and after it, and falls only at the next rising clock (the dummy clock or the first bit of the next byte), or at a start or stop.
- R5: After the read code is acknowledged, the register at the pointer is shifted out on ack_o, inverted and MSB first. Each bit is set at a falling clock and held until the next falling clock.
- R6: In the acknowledge slot of a read byte, a low data line makes the next byte come from the pointer plus one. A high data line makes the slave hold ack_o at 0 until the next start.
- R7: A stop in the middle of a byte drops that byte, and nothing is written. A start without a stop before it (a repeated start) begins a new device byte at once.
- R8: During the acknowledge slot of a read byte, ack_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock from host, asynchronous |
| sda_i | input | 1 | Serial data from host, asynchronous |
| ack_o | output | 1 | Acknowledge and inverted read data |
| reg_we_o | output | 1 | Register write strobe, one clock |
| reg_addr_o | output | ADDR_W | Register pointer |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data at reg_addr_o |

## Verification
A wrong bit counter or a wrong transfer state shows up at ack_o within one byte time, as a missing or misplaced acknowledge or as a misaligned inverted read bit. A pointer that fails to step shows up on the next strobe as the wrong reg_addr_o, and on a read burst as a repeated byte. The bench acts as the host and keeps its own model of the register file. It compares every acknowledge slot and every byte read back against the values written, including aborted bytes and foreign device codes, which must leave the model untouched.

// File: rtl/twr_pkg.sv
package twr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_PTR,
    ST_WDATA,
    ST_RFIRST,
    ST_RDATA,
    ST_SKIP
  } twr_state_e;
endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/twr_cond.sv
module twr_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_p_q, sda_p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= scl_s_i;
      sda_p_q <= sda_s_i;
    end
  end

  assign scl_rise_o = !scl_p_q && scl_s_i;
  assign scl_fall_o = scl_p_q && !scl_s_i;
  // data edges with clock high in both samples
  assign start_o    = scl_p_q && scl_s_i && sda_p_q && !sda_s_i;
  assign stop_o     = scl_p_q && scl_s_i && !sda_p_q && sda_s_i;
endmodule

// File: rtl/twr_fsm.sv
module twr_fsm
  import twr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h12,
  parameter int         ADDR_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [7:0]        reg_rdata_i,
  output logic              ack_o,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [7:0]        reg_wdata_o
);
  localparam logic [7:0] WR_CODE = {DEV_ADDR, 1'b0};
  localparam logic [7:0] RD_CODE = {DEV_ADDR, 1'b1};
  localparam logic [3:0] ACK_IDX = 4'd8;

  twr_state_e        st_q;
  logic [3:0]        idx_q;
  logic [7:0]        sh_q, rd_q, wd_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              ack_q, pend_q, we_q;
  logic [7:0]        byte_in;

  assign byte_in = {sh_q[6:0], sda_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      sh_q   <= '0;
      rd_q   <= '0;
      wd_q   <= '0;
      ptr_q  <= '0;
      ack_q  <= 1'b0;
      pend_q <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      we_q <= 1'b0;
      // pointer steps the cycle after the strobe
      if (we_q) ptr_q <= ptr_q + 1'b1;
      if (start_i) begin
        st_q   <= ST_DEV;
        idx_q  <= '0;
        ack_q  <= 1'b0;
        pend_q <= 1'b0;
      end else if (stop_i) begin
        st_q   <= ST_IDLE;
        idx_q  <= '0;
        ack_q  <= 1'b0;
        pend_q <= 1'b0;
      end else if (st_q != ST_IDLE) begin
        if (scl_rise_i) begin
          if (idx_q == ACK_IDX) begin
            idx_q <= '0;
            case (st_q)
              ST_RFIRST: begin
                rd_q <= reg_rdata_i;
                st_q <= ST_RDATA;
              end
              ST_RDATA: begin
                if (!sda_s_i) rd_q <= reg_rdata_i;
                else          st_q <= ST_SKIP;
              end
              default: ;
            endcase
          end else begin
            idx_q <= idx_q + 1'b1;
            sh_q  <= byte_in;
            if (idx_q == 4'd0 && st_q != ST_RDATA) ack_q <= 1'b0;
            if (idx_q == 4'd7) begin
              case (st_q)
                ST_DEV: begin
                  if (byte_in == WR_CODE) begin
                    st_q   <= ST_PTR;
                    pend_q <= 1'b1;
                  end else if (byte_in == RD_CODE) begin
                    st_q   <= ST_RFIRST;
                    pend_q <= 1'b1;
                  end else begin
                    st_q <= ST_SKIP;
                  end
                end
                ST_PTR: begin
                  ptr_q  <= ADDR_W'(byte_in);
                  st_q   <= ST_WDATA;
                  pend_q <= 1'b1;
                end
                ST_WDATA: begin
                  we_q   <= 1'b1;
                  wd_q   <= byte_in;
                  pend_q <= 1'b1;
                end
                ST_RDATA: ptr_q <= ptr_q + 1'b1;
                default: ;
              endcase
            end
          end
        end else if (scl_fall_i) begin
          if (idx_q == ACK_IDX) begin
            if (pend_q) begin
              ack_q  <= 1'b1;
              pend_q <= 1'b0;
            end else if (st_q == ST_RDATA) begin
              ack_q <= 1'b0;
            end
          end else if (st_q == ST_RDATA) begin
            ack_q <= ~rd_q[~idx_q[2:0]];
          end
        end
      end
    end
  end

  assign ack_o       = ack_q;
  assign reg_we_o    = we_q;
  assign reg_addr_o  = ptr_q;
  assign reg_wdata_o = wd_q;
endmodule

// File: rtl/twr_slave.sv
module twr_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h12,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              ack_o,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [7:0]        reg_wdata_o,
  input  logic [7:0]        reg_rdata_i
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw, line_s;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    twr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (line_raw[g]),
      .q_o   (line_s[g])
    );
  end

  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  twr_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  twr_fsm #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .reg_rdata_i(reg_rdata_i),
    .ack_o      (ack_o),
    .reg_we_o   (reg_we_o),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o)
  );
endmodule

// File: rtl/twr_slave_chk.sv
module twr_slave_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_o,
  input logic              reg_we_o,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic              scl_rise,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det
);
  // R3
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R3
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> reg_addr_o == ADDR_W'($past(reg_addr_o) + 1'b1));

  // R3
  we_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $past(scl_rise));

  // R5
  ack_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o != $past(ack_o)) |-> $past(scl_fall || scl_rise || start_det || stop_det));

  // R7
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !ack_o);
endmodule

bind twr_slave twr_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ack_o     (ack_o),
  .reg_we_o  (reg_we_o),
  .reg_addr_o(reg_addr_o),
  .scl_rise  (scl_rise),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det)
);

// File: tb/twr_slave_bench.sv
`timescale 1ns/1ps
module twr_slave_bench;
  localparam int CLK_PERIOD = 70;
  localparam int Q = 5;
  localparam logic [7:0] WR = 8'h24;
  localparam logic [7:0] RD = 8'h25;
  localparam int NVEC = 6;
  localparam logic [15:0] VEC [0:NVEC-1] =
    '{16'h00AA, 16'h0155, 16'h07FF, 16'h085A, 16'h0A00, 16'h0F81};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda = 1'b1;
  logic ack, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [0:15];
  int checks = 0, errors = 0, we_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twr_slave u_twr_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .ack_o(ack),
    .reg_we_o(reg_we), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_rdata_i(reg_rdata));

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 8'h00;
    end else if (reg_we) begin
      we_cnt <= we_cnt + 1;
      if (reg_addr < 8'd16) mem[reg_addr[3:0]] <= reg_wdata;
    end
  end
  assign reg_rdata = (reg_addr < 8'd16) ? mem[reg_addr[3:0]] : 8'h00;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda = 1'b1; wq(); scl = 1'b1; wq(); sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda = 1'b0; wq(); scl = 1'b1; wq(); sda = 1'b1; wq();
  endtask

  task automatic clk_bit(input logic b);
    sda = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    sda = 1'b1; wq(); scl = 1'b1; wq(); a = ack; wq(); scl = 1'b0; wq();
  endtask

  task automatic read_byte(input bit more, output logic [7:0] b, output logic slot);
    for (int i = 7; i >= 0; i--) begin
      sda = 1'b1; wq(); scl = 1'b1; wq(); b[i] = ~ack; wq(); scl = 1'b0; wq();
    end
    sda = more ? 1'b0 : 1'b1; wq(); scl = 1'b1; wq(); slot = ack; wq(); scl = 1'b0; wq();
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic a;
    bus_start(); send_byte(WR, a); send_byte(p, a); clk_bit(1'b1); bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %h expected %h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a, slot;
    logic [7:0] b;
    int wc;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ack == 1'b0 && reg_we == 1'b0 && reg_addr == 8'h00, "R1", {ack, reg_we, reg_addr}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ack == 1'b0 && reg_addr == 8'h00, "R1", {ack, reg_addr}, 0);

    // vector table: single write then read back
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] ad, dt;
      ad = VEC[v][15:8]; dt = VEC[v][7:0];
      bus_start();
      send_byte(WR, a); chk(a == 1'b1, "R2", a, 1);
      send_byte(ad, a); chk(a == 1'b1, "R4", a, 1);
      send_byte(dt, a); chk(a == 1'b1, "R4", a, 1);
      clk_bit(1'b1); bus_stop();
      chk(mem[ad[3:0]] == dt, "R3", mem[ad[3:0]], dt);
      set_ptr(ad);
      bus_start();
      send_byte(RD, a); chk(a == 1'b1, "R5", a, 1);
      read_byte(1'b0, b, slot); bus_stop();
      chk(b == dt, "R5", b, dt);
      chk(slot == 1'b0, "R8", slot, 0);
    end

    // burst write, ack held until dummy clock
    bus_start(); send_byte(WR, a); send_byte(8'h04, a);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
    chk(a == 1'b1, "R4", a, 1);
    wq(); wq(); wq(); wq();
    chk(ack == 1'b1, "R4", ack, 1);
    clk_bit(1'b1);
    chk(ack == 1'b0, "R4", ack, 0);
    bus_stop();
    chk(mem[4] == 8'h11 && mem[5] == 8'h22 && mem[6] == 8'h33, "R3",
        {mem[4], mem[5], mem[6]}, 24'h112233);

    // burst read with master ack, then nack
    set_ptr(8'h04);
    bus_start(); send_byte(RD, a);
    read_byte(1'b1, b, slot); chk(b == 8'h11, "R6", b, 8'h11);
    chk(slot == 1'b0, "R8", slot, 0);
    read_byte(1'b1, b, slot); chk(b == 8'h22, "R6", b, 8'h22);
    read_byte(1'b0, b, slot); chk(b == 8'h33, "R6", b, 8'h33);
    for (int i = 0; i < 8; i++) begin
      sda = 1'b1; wq(); scl = 1'b1; wq();
      chk(ack == 1'b0, "R6", ack, 0);
      wq(); scl = 1'b0; wq();
    end
    bus_stop();

    // foreign device code
    wc = we_cnt;
    bus_start(); send_byte(8'h30, a); chk(a == 1'b0, "R2", a, 0);
    send_byte(8'h05, a); chk(a == 1'b0, "R2", a, 0);
    send_byte(8'hEE, a); bus_stop();
    chk(we_cnt == wc, "R2", we_cnt, wc);

    // stop in the middle of a data byte
    wc = we_cnt;
    bus_start(); send_byte(WR, a); send_byte(8'h03, a);
    for (int i = 0; i < 4; i++) clk_bit(1'b0);
    bus_stop();
    chk(we_cnt == wc && mem[3] == 8'h00, "R7", {we_cnt[7:0], mem[3]}, {wc[7:0], 8'h00});

    // repeated start switches to read at pointer 8
    bus_start(); send_byte(WR, a); send_byte(8'h08, a);
    bus_start(); send_byte(RD, a); chk(a == 1'b1, "R7", a, 1);
    read_byte(1'b0, b, slot); bus_stop();
    chk(b == 8'h5A, "R7", b, 8'h5A);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule